// File: doc/BRIEF.md
# Periodic Whole-Second Drift Trimmer

The trimmer sits between a one-second tick source and a seconds counter and corrects long-term clock drift by whole seconds. Software measures the drift and loads one 32-bit configuration word that holds a period, a direction and an enable. After every (period + 1) seconds the trimmer changes the increment it passes on. It either drops that second, so the counter does not advance, or doubles it, so the counter advances by two. All other seconds pass through as a single increment.

Each clock cycle the trimmer issues an increment request of 0, 1 or 2. The request is registered and appears one clock after the tick that caused it. It is 0 in every cycle that follows a clock with no tick. Loading a new word restarts the period count. A correction therefore always falls on the (period + 1)-th tick after the load.

Top module: `sec_trimmer`

## Requirements
- R1: After synchronous reset the increment output is 0 and the stored word is all zero. Ticks that follow then pass as single increments until a word is loaded.
- R2: In the cycle after a clock edge with `tick_i` low, `inc_o` is 0.
- R3: When bit 23 (enable) of the stored word is 0, or the direction code is 0 or 1, every tick produces `inc_o` = 1.
- R4: With enable set and direction code 2 (drop), the tick that closes a period produces `inc_o` = 0. Every other tick produces 1.
- R5: With enable set and direction code 3 (add), the tick that closes a period produces `inc_o` = 2. Every other tick produces 1.
- R6: With period value M, the correction falls on ticks M+1, 2(M+1), 3(M+1) and so on, counted after the load. With M = 0 it falls on every tick.
- R7: A load clears the tick count. A tick in the same cycle as a load produces `inc_o` = 1 and is not counted.
- R8: The period is bits 18:0 of `cfg_data_i`, the direction code is bits 20:19 and the enable is bit 23. Bits 22:21 and 31:24 have no effect.
- R9: `inc_o` changes only at a clock edge. It reflects the tick sampled at that edge, which gives one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Load strobe for the configuration word |
| cfg_data_i | input | 32 | Configuration word (period, direction code, enable) |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| inc_o | output | 2 | Increment request to the seconds counter: 0, 1 or 2 |

## Verification
A configuration load and a second tick can arrive in the same cycle. In that cycle the load must win the counter while the tick still passes through as a plain single increment. The bench raises the load strobe and the tick together. It expects 1 for that tick, and it expects the correction on the (M+1)-th later tick, not one tick earlier. A second directed test reloads the word in the middle of a period to confirm the restart.

// File: rtl/trim_pkg.sv
package trim_pkg;

    localparam int CFG_W     = 32;
    localparam int PERIOD_W  = 19;
    localparam int CODE_LSB  = 19;
    localparam int CODE_W    = 2;
    localparam int ENABLE_B  = 23;
    localparam int INC_W     = 2;

    typedef enum logic [CODE_W-1:0] {
        DIR_OFF0 = 2'd0,
        DIR_OFF1 = 2'd1,
        DIR_DROP = 2'd2,
        DIR_ADD  = 2'd3
    } dir_e;

    typedef enum logic [INC_W-1:0] {
        INC_NONE = 2'd0,
        INC_ONE  = 2'd1,
        INC_TWO  = 2'd2
    } inc_e;

    typedef struct packed {
        logic                enable;
        dir_e                dir;
        logic [PERIOD_W-1:0] period;
    } trim_cfg_t;

    function automatic trim_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        trim_cfg_t c;
        c.enable = w[ENABLE_B];
        c.dir    = dir_e'(w[CODE_LSB +: CODE_W]);
        c.period = w[PERIOD_W-1:0];
        return c;
    endfunction

    function automatic logic cfg_active(input trim_cfg_t c);
        return c.enable && (c.dir == DIR_DROP || c.dir == DIR_ADD);
    endfunction

endpackage

// File: rtl/trim_cfg_reg.sv
module trim_cfg_reg
    import trim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  logic [CFG_W-1:0]    data_i,
    output logic                active_o,
    output logic                add_o,
    output logic [PERIOD_W-1:0] period_o
);

    trim_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_i) begin
            cfg_q <= unpack_cfg(data_i);
        end
    end

    assign active_o = cfg_active(cfg_q);
    assign add_o    = (cfg_q.dir == DIR_ADD);
    assign period_o = cfg_q.period;

    // R8
    period_field_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> period_o == $past(data_i[PERIOD_W-1:0]));

    // R3
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i && !data_i[ENABLE_B] |=> !active_o);

endmodule

// File: rtl/trim_period_ctr.sv
module trim_period_ctr
    import trim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  logic                tick_i,
    input  logic                active_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                fire_o
);

    logic [PERIOD_W-1:0] cnt_q;
    logic                at_end;

    assign at_end = (cnt_q == period_i);
    assign fire_o = tick_i && active_i && !wr_i && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_i) begin
            cnt_q <= '0;
        end else if (tick_i && active_i) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> cnt_q == '0);

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> cnt_q == '0);

    // R6
    in_range_chk: assert property (@(posedge clk) disable iff (rst)
        active_i |-> cnt_q <= period_i);

endmodule

// File: rtl/trim_inc_shaper.sv
module trim_inc_shaper
    import trim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             fire_i,
    input  logic             add_i,
    output logic [INC_W-1:0] inc_o
);

    inc_e inc_q;
    inc_e inc_d;

    always_comb begin
        inc_d = INC_NONE;
        if (tick_i) begin
            if (fire_i) begin
                inc_d = add_i ? INC_TWO : INC_NONE;
            end else begin
                inc_d = INC_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inc_q <= INC_NONE;
        end else begin
            inc_q <= inc_d;
        end
    end

    assign inc_o = inc_q;

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> inc_o == INC_NONE);

    // R3
    plain_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick_i && !fire_i |=> inc_o == INC_ONE);

    // R4
    drop_chk: assert property (@(posedge clk) disable iff (rst)
        tick_i && fire_i && !add_i |=> inc_o == INC_NONE);

    // R5
    add_chk: assert property (@(posedge clk) disable iff (rst)
        tick_i && fire_i && add_i |=> inc_o == INC_TWO);

    // R9
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        inc_o != 2'd3);

endmodule

// File: rtl/sec_trimmer.sv
module sec_trimmer
    import trim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_i,
    input  logic [31:0]      cfg_data_i,
    input  logic             tick_i,
    output logic [1:0]       inc_o
);

    logic                active;
    logic                add_dir;
    logic [PERIOD_W-1:0] period;
    logic                fire;

    trim_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (cfg_wr_i),
        .data_i   (cfg_data_i),
        .active_o (active),
        .add_o    (add_dir),
        .period_o (period)
    );

    trim_period_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (cfg_wr_i),
        .tick_i   (tick_i),
        .active_i (active),
        .period_i (period),
        .fire_o   (fire)
    );

    trim_inc_shaper u_shp (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .fire_i (fire),
        .add_i  (add_dir),
        .inc_o  (inc_o)
    );

    // R7
    load_tick_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_i && tick_i |=> inc_o == 2'd1);

endmodule

// File: tb/sim_sec_trimmer.sv
module sim_sec_trimmer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        tick = 1'b0;
    logic [1:0]  inc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sec_trimmer u0 (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr_i   (cfg_wr),
        .cfg_data_i (cfg_data),
        .tick_i     (tick),
        .inc_o      (inc)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [31:0] cfg;
        logic [7:0]  n;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [0:NV-1] = '{
        '{tag: "R3 ", cfg: 32'h0000_0000, n: 8'd4},
        '{tag: "R5 ", cfg: 32'h0098_0002, n: 8'd9},
        '{tag: "R4 ", cfg: 32'h0090_0003, n: 8'd8},
        '{tag: "R6 ", cfg: 32'h0098_0000, n: 8'd3},
        '{tag: "R3 ", cfg: 32'h0018_0001, n: 8'd4},
        '{tag: "R3 ", cfg: 32'h0088_0000, n: 8'd3},
        '{tag: "R8 ", cfg: 32'hFFF0_0001, n: 8'd6}
    };

    function automatic logic [1:0] model(input logic [31:0] c, input int k);
        int m;
        m = int'(c[18:0]);
        if (c[23] && c[20] && ((k % (m + 1)) == m))
            return c[19] ? 2'd2 : 2'd0;
        return 2'd1;
    endfunction

    task automatic check(input string req, input logic [1:0] exp);
        checks++;
        if (inc !== exp) begin
            errors++;
            $display("FAIL %s: inc=%0d expected %0d", req, inc, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [31:0] d, input logic tk);
        @(negedge clk);
        cfg_wr   = wr;
        cfg_data = d;
        tick     = tk;
        @(posedge clk);
        #1;
        @(negedge clk);
        cfg_wr = 1'b0;
        tick   = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", 2'd0);

        // R1: with no word loaded, a tick passes as 1
        step(1'b0, '0, 1'b1);
        check("R1", 2'd1);

        // R9: output holds before the edge, updates after it
        @(negedge clk);
        tick = 1'b1;
        #2;
        check("R9", 2'd0);
        @(posedge clk);
        #1;
        check("R9", 2'd1);
        @(negedge clk);
        tick = 1'b0;

        // Vector table
        for (int v = 0; v < NV; v++) begin
            step(1'b1, VEC[v].cfg, 1'b0);
            check("R2", 2'd0);
            for (int k = 0; k < int'(VEC[v].n); k++) begin
                step(1'b0, '0, 1'b1);
                check(string'(VEC[v].tag), model(VEC[v].cfg, k));
                step(1'b0, '0, 1'b0);
                check("R2", 2'd0);
            end
        end

        // R7: load and tick in the same cycle
        step(1'b1, 32'h0098_0001, 1'b1);
        check("R7", 2'd1);
        step(1'b0, '0, 1'b1);
        check("R7", 2'd1);
        step(1'b0, '0, 1'b1);
        check("R7", 2'd2);

        // R7: reload in mid period restarts the count
        step(1'b1, 32'h0098_0002, 1'b0);
        step(1'b0, '0, 1'b1);
        check("R7", 2'd1);
        step(1'b0, '0, 1'b1);
        check("R7", 2'd1);
        step(1'b1, 32'h0098_0002, 1'b0);
        step(1'b0, '0, 1'b1);
        check("R7", 2'd1);
        step(1'b0, '0, 1'b1);
        check("R7", 2'd1);
        step(1'b0, '0, 1'b1);
        check("R7", 2'd2);

        // R1: reset clears the word
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", 2'd0);
        for (int k = 0; k < 4; k++) begin
            step(1'b0, '0, 1'b1);
            check("R1", 2'd1);
        end

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run hung, done=0 expected 1");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule